// File: doc/BRIEF.md
# Two-Stage Parallel-to-Serial Converter

This block accepts a parallel word, keeps it in a holding register, and turns it into a serial bit stream. Software or a neighbouring block presents the word and pulses a capture strobe. The holding register then keeps that word until the next capture. A separate shift register takes its contents from the holding register, never from the input pins. Each pulse of the shift strobe then moves the word one place toward the serial output.

Both stages run on one system clock. Single-cycle enable strobes stand in for two independent clocks. The shift stage has two active-low controls, one to copy the held word in and one to empty it. Either control wins over shifting for every cycle it is held low. On each shift the first stage takes the serial input, so several units can be chained output-to-input. Emptying the shift stage does not touch the holding register, so the same word can be sent again.

Top module: `piso_latched`

## Requirements
- R1: While `rst_n` is low, both registers are zero and `ser_out` is 0. After release, a load with no prior capture produces 0 on `ser_out`.
- R2: A cycle with `cap_stb` high stores `par_in` in the holding register. In any other cycle the holding register keeps its value.
- R3: A cycle with `clr_n` high and `load_n` low copies the holding register into the shift register. `ser_out` then shows bit WIDTH-1 of the held word after that clock edge.
- R4: In a cycle with `sh_stb` high and both controls high, each bit moves one place toward the output and bit 0 takes `ser_in`. The word therefore leaves on `ser_out` most significant bit first, and after WIDTH shifts the output shows the serial input bits in the order they were applied.
- R5: A cycle with `clr_n` low makes the shift register zero, whatever `load_n` and `sh_stb` are.
- R6: A cycle with `load_n` low and `sh_stb` high loads and does not shift.
- R7: Emptying the shift register leaves the holding register unchanged, so a later load delivers the same word again.
- R8: When `cap_stb` and a load fall in the same cycle, the shift register takes the previously held word. The new word becomes available to the next load.
- R9: With `sh_stb` low and both controls high, the shift register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_in | input | WIDTH | Parallel word to capture |
| cap_stb | input | 1 | Capture strobe for the holding register |
| sh_stb | input | 1 | Shift strobe for the shift register |
| ser_in | input | 1 | Serial input into the first shift stage |
| load_n | input | 1 | Copy held word into shift register, active low |
| clr_n | input | 1 | Empty the shift register, active low |
| ser_out | output | 1 | Last shift stage |

## Verification
Capture and load can fall in the same clock. The bench provokes this by holding one word, then pulsing `cap_stb` with a word of opposite top bit while `load_n` is low. It judges the result by `ser_out` right after that edge and again after a second load. The controls also collide with each other: clear, load and shift strobes are raised together and in pairs. Each combination is judged against a bench model that applies clear over load over shift.

// File: rtl/piso_pkg.sv
package piso_pkg;

  // One shift step: move toward the top bit, refill bit 0 from the serial input.
  function automatic logic [63:0] shift_word(input logic [63:0] cur, input logic sin, input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i == 0) r[i] = sin;
      else if (i < w) r[i] = cur[i-1];
    end
    return r;
  endfunction

endpackage

// File: rtl/piso_hold_stage.sv
module piso_hold_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= d_in;
  end

  AST_HOLD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> q == $past(d_in)); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(q)); // R2

endmodule

// File: rtl/piso_shift_stage.sv
module piso_shift_stage
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             shift_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_src,
  output logic [WIDTH-1:0] q,
  output logic             ser_out
);

  localparam int TOP = WIDTH - 1;

  logic ev_clear, ev_load, ev_shift;
  logic [63:0] shifted_wide;
  logic [WIDTH-1:0] shifted;

  assign ev_clear = !clr_n;
  assign ev_load  = clr_n && !load_n;
  assign ev_shift = clr_n && load_n && shift_en;

  assign shifted_wide = shift_word(64'(q), ser_in, WIDTH);
  assign shifted      = shifted_wide[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (ev_clear) q <= '0;
    else if (ev_load)  q <= par_src;
    else if (ev_shift) q <= shifted;
  end

  assign ser_out = q[TOP];

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> q == '0); // R5
  AST_LOAD_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> q == $past(par_src)); // R6
  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shift |=> (q[TOP:1] == $past(q[TOP-1:0])) && (q[0] == $past(ser_in))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !shift_en) |=> $stable(q)); // R9

endmodule

// File: rtl/piso_latched.sv
module piso_latched #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             cap_stb,
  input  logic             sh_stb,
  input  logic             ser_in,
  input  logic             load_n,
  input  logic             clr_n,
  output logic             ser_out
);

  logic [WIDTH-1:0] held_word;
  logic [WIDTH-1:0] shift_word_q;

  piso_hold_stage #(.WIDTH(WIDTH)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_stb),
    .d_in   (par_in),
    .q      (held_word)
  );

  piso_shift_stage #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .shift_en (sh_stb),
    .ser_in   (ser_in),
    .par_src  (held_word),
    .q        (shift_word_q),
    .ser_out  (ser_out)
  );

  AST_CLEAR_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && !cap_stb) |=> $stable(held_word)); // R7
  AST_SAME_CYCLE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_stb && clr_n && !load_n) |=> shift_word_q == $past(held_word)); // R8
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (ser_out == 1'b0)); // R1

endmodule

// File: tb/piso_latched_test.sv
module piso_latched_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] par_in;
  logic cap_stb, sh_stb, ser_in, load_n, clr_n;
  logic ser_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] m_hold, m_sh;

  // word to send, serial fill to push in behind it
  localparam logic [15:0] VEC [6] = '{
    16'hA5_3C, 16'h01_FF, 16'h80_00, 16'hFF_81, 16'h5A_96, 16'h00_7E
  };

  piso_latched #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .cap_stb(cap_stb),
    .sh_stb(sh_stb), .ser_in(ser_in), .load_n(load_n), .clr_n(clr_n),
    .ser_out(ser_out)
  );

  always #4 clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: ser_out=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // one clock of stimulus, model update, then a check away from the edge
  task automatic step(input logic cap, input logic [W-1:0] word, input logic sh,
                      input logic sin, input logic ld_n, input logic cl_n,
                      input string req);
    @(negedge clk);
    cap_stb = cap; par_in = word; sh_stb = sh; ser_in = sin;
    load_n = ld_n; clr_n = cl_n;
    @(posedge clk);
    if (!cl_n)     m_sh = '0;
    else if (!ld_n) m_sh = m_hold;
    else if (sh)   m_sh = {m_sh[W-2:0], sin};
    if (cap) m_hold = word;
    #1;
    check(ser_out, m_sh[W-1], req);
  endtask

  task automatic idle(input string req);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; par_in = '0; cap_stb = 0; sh_stb = 0; ser_in = 0;
    load_n = 1; clr_n = 1;
    m_hold = '0; m_sh = '0;
    repeat (3) @(posedge clk);
    #1;
    check(ser_out, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: load straight after reset brings out a zero word
    step(1'b0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, "R1 load after reset");
    for (int k = 0; k < W; k++) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R1 shift zero");

    // table walk: R2 capture, R3 load, R4 shift out then fill
    foreach (VEC[v]) begin
      step(1'b1, VEC[v][15:8], 1'b0, 1'b0, 1'b1, 1'b1, "R2 capture");
      step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R3 load");
      for (int k = 0; k < 2*W; k++)
        step(1'b0, 8'h00, 1'b1, VEC[v][7 - (k % W)], 1'b1, 1'b1, "R4 shift");
    end

    // R9: hold with no strobe
    step(1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, "R9 setup");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R9 load");
    for (int k = 0; k < 3; k++) idle("R9 idle hold");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R9 shift after idle");

    // R6: load with shift strobe high does not shift
    step(1'b1, 8'hC0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 setup");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R6 load beats shift");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, "R6 load held");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R6 first shift");
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R6 second shift");

    // R5: clear beats load and shift; R7: held word survives
    step(1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, "R5 setup");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R5 load");
    step(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0, "R5 clear beats all");
    for (int k = 0; k < W; k++) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R5 empty");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R7 reload after clear");
    for (int k = 0; k < W; k++) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R7 word intact");

    // R8: capture and load together
    step(1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, "R8 setup");
    step(1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b1, "R8 old word loaded");
    check(ser_out, 1'b1, "R8 old top bit");
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, "R8 new word next load");
    check(ser_out, 1'b0, "R8 new top bit");
    for (int k = 0; k < W; k++) step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R8 new word out");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule